// File: doc/BRIEF.md
# Four-Lane Swizzle Move Unit

This block rearranges a short subvector of up to four 32-bit elements under a 12-bit immediate. The immediate holds one 3-bit selector per destination lane. A selector can copy any source lane into its lane. It can also write the constant zero or the constant one, in integer or single-precision float form. A third choice skips the lane, which leaves the destination element as it was. The source and destination lane counts are set on their own, so a three-element source can feed a two-element destination.

Operands arrive as a pair of 64-bit register halves, and results leave in the same form. The block also produces a per-lane write enable for the register file that sits beside it. All enables of one operation are issued together in a single registered cycle, so a partial result is never visible. Any illegal condition suppresses every enable of that operation. The illegal conditions are an odd register number, a reserved selector code, or a reference to a source lane outside the source length.

Top module: `swz_move_unit`

## Requirements
- R1: The selector for destination lane i (0=X, 1=Y, 2=Z, 3=W) is `swz_imm[3i+2:3i]`. Lane 0 sits in bits 31:0 and lane 1 in bits 63:32 of the low half, `src_lo` and `res_lo`. Lane 2 sits in bits 31:0 and lane 3 in bits 63:32 of the high half, `src_hi` and `res_hi`.
- R2: A selector of the form 3'b1NN writes source lane NN into its destination lane and raises that lane's write enable.
- R3: Selector 3'b011 writes the constant one and raises the lane enable. The value is 32'h0000_0001 when `is_float` is 0 and 32'h3F80_0000 when `is_float` is 1.
- R4: Selector 3'b010 writes the value 32'h0000_0000 and raises the lane enable, for both values of `is_float`.
- R5: Selector 3'b000 skips its lane. The lane's enable stays low and its result field reads zero.
- R6: Lanes with an index above `dst_len_m1` (destination length minus one) are never written, and their selectors are ignored, including reserved codes and out-of-range lane numbers.
- R7: On a live lane, a selector 3'b1NN with NN greater than `src_len_m1` raises `err_range`, and all enables of that operation are low.
- R8: The reserved selector 3'b001 on a live lane raises `err_encoding`, and all enables of that operation are low.
- R9: An odd `src_reg` or `dst_reg` (bit 0 set) raises `err_operand`, and all enables of that operation are low.
- R10: All results are registered. The outputs for an operation accepted with `in_valid` high appear on the next clock edge with `out_valid` high and `out_reg` equal to `dst_reg`. In a cycle after `in_valid` was low, every output is zero.
- R11: The enables of one operation are all raised in the same single cycle, and never while `out_valid` is low. Every result field whose enable is low reads zero.
- R12: While `rst` is high and on the edge that ends it, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| swz_imm | input | 12 | Four 3-bit lane selectors |
| is_float | input | 1 | Constant one is written as 1.0 instead of integer 1 |
| src_len_m1 | input | 2 | Source subvector length minus one |
| dst_len_m1 | input | 2 | Destination subvector length minus one |
| src_reg | input | 5 | Source register pair number |
| dst_reg | input | 5 | Destination register pair number |
| src_lo | input | 64 | Source lanes 0 and 1 |
| src_hi | input | 64 | Source lanes 2 and 3 |
| out_valid | output | 1 | Result cycle of an operation |
| out_reg | output | 5 | Destination register pair number |
| res_lo | output | 64 | Result lanes 0 and 1 |
| res_hi | output | 64 | Result lanes 2 and 3 |
| lane_we | output | 4 | Per-lane write enable, bit i for lane i |
| err_operand | output | 1 | Odd register number |
| err_encoding | output | 1 | Reserved selector on a live lane |
| err_range | output | 1 | Source lane outside source length |

## Verification
Every result is due exactly one clock edge after the cycle in which its operation is presented. The bench drives inputs on the falling edge. On each rising edge it computes the expected outputs from the inputs it sees at that edge. On the following falling edge it compares every output field against those values. This one-edge model is also applied to idle cycles and to the reset cycles, so any output that appears early, late or for two cycles is flagged.

// File: rtl/swz_pkg.sv
package swz_pkg;
  localparam int SEL_W = 3;
  localparam logic [SEL_W-1:0] SEL_SKIP = 3'b000;
  localparam logic [SEL_W-1:0] SEL_RSVD = 3'b001;
  localparam logic [SEL_W-1:0] SEL_ZERO = 3'b010;
  localparam logic [SEL_W-1:0] SEL_ONE  = 3'b011;
endpackage

// File: rtl/swz_lane.sv
module swz_lane
  import swz_pkg::*;
#(
  parameter int          ELEM_W    = 32,
  parameter int          LANES     = 4,
  parameter int          IDX       = 0,
  parameter logic [31:0] FLOAT_ONE = 32'h3F80_0000,
  localparam int         LEN_W     = $clog2(LANES)
) (
  input  logic [SEL_W-1:0]         sel,
  input  logic [LANES*ELEM_W-1:0]  src_flat,
  input  logic                     is_float,
  input  logic [LEN_W-1:0]         src_len_m1,
  input  logic [LEN_W-1:0]         dst_len_m1,
  output logic [ELEM_W-1:0]        data,
  output logic                     wr,
  output logic                     bad_enc,
  output logic                     bad_rng
);
  logic live;
  logic [LEN_W-1:0] pick;

  assign live = (LEN_W'(IDX) <= dst_len_m1);
  assign pick = sel[LEN_W-1:0];

  always_comb begin
    data    = '0;
    wr      = 1'b0;
    bad_enc = 1'b0;
    bad_rng = 1'b0;
    if (live) begin
      if (sel[SEL_W-1]) begin
        wr      = 1'b1;
        data    = src_flat[int'(pick)*ELEM_W +: ELEM_W];
        bad_rng = (pick > src_len_m1);
      end else begin
        unique case (sel)
          SEL_SKIP: wr = 1'b0;
          SEL_RSVD: bad_enc = 1'b1;
          SEL_ZERO: begin
            wr   = 1'b1;
            data = '0;
          end
          default: begin
            wr   = 1'b1;
            data = is_float ? FLOAT_ONE[ELEM_W-1:0] : ELEM_W'(1);
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/swz_guard.sv
module swz_guard #(
  parameter int LANES = 4,
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src_reg,
  input  logic [REG_W-1:0] dst_reg,
  input  logic [LANES-1:0] lane_bad_enc,
  input  logic [LANES-1:0] lane_bad_rng,
  output logic             odd_reg,
  output logic             any_enc,
  output logic             any_rng,
  output logic             block
);
  assign odd_reg = src_reg[0] | dst_reg[0];
  assign any_enc = |lane_bad_enc;
  assign any_rng = |lane_bad_rng;
  assign block   = odd_reg | any_enc | any_rng;
endmodule

// File: rtl/swz_move_unit.sv
module swz_move_unit
  import swz_pkg::*;
#(
  parameter int          ELEM_W    = 32,
  parameter int          LANES     = 4,
  parameter int          REG_W     = 5,
  parameter logic [31:0] FLOAT_ONE = 32'h3F80_0000,
  localparam int         LEN_W     = $clog2(LANES),
  localparam int         IMM_W     = LANES*SEL_W,
  localparam int         VEC_W     = LANES*ELEM_W,
  localparam int         HALF_W    = VEC_W/2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [IMM_W-1:0]  swz_imm,
  input  logic              is_float,
  input  logic [LEN_W-1:0]  src_len_m1,
  input  logic [LEN_W-1:0]  dst_len_m1,
  input  logic [REG_W-1:0]  src_reg,
  input  logic [REG_W-1:0]  dst_reg,
  input  logic [HALF_W-1:0] src_lo,
  input  logic [HALF_W-1:0] src_hi,
  output logic              out_valid,
  output logic [REG_W-1:0]  out_reg,
  output logic [HALF_W-1:0] res_lo,
  output logic [HALF_W-1:0] res_hi,
  output logic [LANES-1:0]  lane_we,
  output logic              err_operand,
  output logic              err_encoding,
  output logic              err_range
);
  logic [VEC_W-1:0] src_flat;
  logic [VEC_W-1:0] lane_data;
  logic [LANES-1:0] lane_wr, lane_enc, lane_rng;
  logic odd_reg, any_enc, any_rng, block;
  logic [VEC_W-1:0] res_q;

  assign src_flat = {src_hi, src_lo};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    swz_lane #(
      .ELEM_W(ELEM_W), .LANES(LANES), .IDX(g), .FLOAT_ONE(FLOAT_ONE)
    ) i_lane (
      .sel        (swz_imm[g*SEL_W +: SEL_W]),
      .src_flat   (src_flat),
      .is_float   (is_float),
      .src_len_m1 (src_len_m1),
      .dst_len_m1 (dst_len_m1),
      .data       (lane_data[g*ELEM_W +: ELEM_W]),
      .wr         (lane_wr[g]),
      .bad_enc    (lane_enc[g]),
      .bad_rng    (lane_rng[g])
    );
  end

  swz_guard #(.LANES(LANES), .REG_W(REG_W)) i_guard (
    .src_reg      (src_reg),
    .dst_reg      (dst_reg),
    .lane_bad_enc (lane_enc),
    .lane_bad_rng (lane_rng),
    .odd_reg      (odd_reg),
    .any_enc      (any_enc),
    .any_rng      (any_rng),
    .block        (block)
  );

  always_ff @(posedge clk) begin
    if (rst || !in_valid) begin
      out_valid    <= 1'b0;
      out_reg      <= '0;
      lane_we      <= '0;
      res_q        <= '0;
      err_operand  <= 1'b0;
      err_encoding <= 1'b0;
      err_range    <= 1'b0;
    end else begin
      out_valid    <= 1'b1;
      out_reg      <= dst_reg;
      err_operand  <= odd_reg;
      err_encoding <= any_enc;
      err_range    <= any_rng;
      for (int i = 0; i < LANES; i++) begin
        lane_we[i]                  <= lane_wr[i] & ~block;
        res_q[i*ELEM_W +: ELEM_W]   <= (lane_wr[i] & ~block) ?
                                       lane_data[i*ELEM_W +: ELEM_W] : '0;
      end
    end
  end

  assign res_lo = res_q[HALF_W-1:0];
  assign res_hi = res_q[VEC_W-1:HALF_W];

  // R11
  idle_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> lane_we == '0);
  // R9
  operand_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    err_operand |-> lane_we == '0);
  // R8
  encoding_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    err_encoding |-> lane_we == '0);
  // R7
  range_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    err_range |-> lane_we == '0);
  // R6
  dead_lane_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (lane_we >> ({1'b0, $past(dst_len_m1)} + 3'd1)) == '0);
  // R10
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R10
  valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R5
  skip_lane0_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && swz_imm[SEL_W-1:0] == SEL_SKIP |=> !lane_we[0]);
endmodule

// File: tb/test_swz_move_unit.sv
module test_swz_move_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [11:0] swz_imm = '0;
  logic        is_float = 1'b0;
  logic [1:0]  src_len_m1 = '0, dst_len_m1 = '0;
  logic [4:0]  src_reg = '0, dst_reg = '0;
  logic [63:0] src_lo = '0, src_hi = '0;
  logic        out_valid;
  logic [4:0]  out_reg;
  logic [63:0] res_lo, res_hi;
  logic [3:0]  lane_we;
  logic        err_operand, err_encoding, err_range;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  string cur_tag = "R12";
  string exp_tag = "R12";

  logic        e_valid;
  logic [4:0]  e_reg;
  logic [31:0] e_lane [4];
  logic [3:0]  e_we;
  logic        e_op, e_enc, e_rng;

  always #5 clk = ~clk;

  swz_move_unit i_swz_move_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .swz_imm(swz_imm),
    .is_float(is_float), .src_len_m1(src_len_m1), .dst_len_m1(dst_len_m1),
    .src_reg(src_reg), .dst_reg(dst_reg), .src_lo(src_lo), .src_hi(src_hi),
    .out_valid(out_valid), .out_reg(out_reg), .res_lo(res_lo), .res_hi(res_hi),
    .lane_we(lane_we), .err_operand(err_operand), .err_encoding(err_encoding),
    .err_range(err_range)
  );

  // behavioural reference, one edge of latency
  always @(posedge clk) begin
    logic [31:0] s [4];
    logic [31:0] v [4];
    logic [3:0]  w;
    int live, sl;
    bit eo, ee, er;
    exp_tag = cur_tag;
    s[0] = src_lo[31:0]; s[1] = src_lo[63:32];
    s[2] = src_hi[31:0]; s[3] = src_hi[63:32];
    live = int'(dst_len_m1) + 1;
    sl = int'(src_len_m1) + 1;
    w = '0; eo = 0; ee = 0; er = 0;
    for (int i = 0; i < 4; i++) v[i] = '0;
    if (!rst && in_valid) begin
      eo = src_reg[0] || dst_reg[0];
      for (int i = 0; i < live; i++) begin
        int code;
        code = int'(swz_imm[3*i +: 3]);
        if (code == 1) ee = 1;
        else if (code >= 4) begin
          if (code - 4 >= sl) er = 1;
          v[i] = s[code - 4]; w[i] = 1;
        end else if (code == 2) begin
          v[i] = 0; w[i] = 1;
        end else if (code == 3) begin
          v[i] = is_float ? 32'h3F80_0000 : 32'd1; w[i] = 1;
        end
      end
      if (eo || ee || er) begin
        w = '0;
        for (int i = 0; i < 4; i++) v[i] = '0;
      end
      for (int i = 0; i < 4; i++) if (!w[i]) v[i] = '0;
    end
    e_valid = !rst && in_valid;
    e_reg = (!rst && in_valid) ? dst_reg : '0;
    e_we = w; e_op = eo; e_enc = ee; e_rng = er;
    for (int i = 0; i < 4; i++) e_lane[i] = v[i];
  end

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk(exp_tag, "out_valid (R10)", 64'(out_valid), 64'(e_valid));
      chk(exp_tag, "out_reg (R10)", 64'(out_reg), 64'(e_reg));
      chk(exp_tag, "lane_we (R11)", 64'(lane_we), 64'(e_we));
      chk(exp_tag, "res_lo (R1)", res_lo, {e_lane[1], e_lane[0]});
      chk(exp_tag, "res_hi (R1)", res_hi, {e_lane[3], e_lane[2]});
      chk(exp_tag, "err_operand (R9)", 64'(err_operand), 64'(e_op));
      chk(exp_tag, "err_encoding (R8)", 64'(err_encoding), 64'(e_enc));
      chk(exp_tag, "err_range (R7)", 64'(err_range), 64'(e_rng));
    end
  end

  task automatic op(string tag, logic [11:0] imm, logic fl, logic [1:0] sl,
                    logic [1:0] dl, logic [4:0] sr, logic [4:0] dr);
    @(negedge clk);
    cur_tag = tag; in_valid = 1'b1; swz_imm = imm; is_float = fl;
    src_len_m1 = sl; dst_len_m1 = dl; src_reg = sr; dst_reg = dr;
  endtask

  task automatic idle(string tag, int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      cur_tag = tag; in_valid = 1'b0;
    end
  endtask

  function automatic logic [11:0] sels(logic [2:0] x, logic [2:0] y,
                                       logic [2:0] z, logic [2:0] w);
    return {w, z, y, x};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    src_lo = {32'hB1B1_0001, 32'hA0A0_0000};
    src_hi = {32'hD3D3_0003, 32'hC2C2_0002};
    // R12: reset state compared on each falling edge while rst is high
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle("R10", 2);
    // R1 identity lane placement
    op("R1", sels(3'b100, 3'b101, 3'b110, 3'b111), 0, 2'd3, 2'd3, 5'd2, 5'd4);
    // R2 reversed and broadcast copies
    op("R2", sels(3'b111, 3'b110, 3'b101, 3'b100), 0, 2'd3, 2'd3, 5'd6, 5'd8);
    op("R2", sels(3'b110, 3'b110, 3'b110, 3'b110), 0, 2'd2, 2'd3, 5'd0, 5'd10);
    // R3 constant one, integer then float
    op("R3", sels(3'b011, 3'b100, 3'b011, 3'b011), 0, 2'd0, 2'd3, 5'd2, 5'd2);
    op("R3", sels(3'b011, 3'b100, 3'b011, 3'b011), 1, 2'd0, 2'd3, 5'd2, 5'd2);
    // R4 constant zero in both forms
    op("R4", sels(3'b010, 3'b010, 3'b101, 3'b010), 1, 2'd1, 2'd3, 5'd4, 5'd6);
    op("R4", sels(3'b010, 3'b111, 3'b010, 3'b010), 0, 2'd3, 2'd3, 5'd4, 5'd6);
    // R5 skip pattern W.Y.
    op("R5", sels(3'b111, 3'b000, 3'b101, 3'b000), 0, 2'd3, 2'd3, 5'd12, 5'd14);
    // R6 two-lane destination: dead lanes hold reserved and out-of-range codes
    op("R6", sels(3'b110, 3'b100, 3'b001, 3'b111), 0, 2'd2, 2'd1, 5'd0, 5'd2);
    op("R6", sels(3'b101, 3'b001, 3'b001, 3'b001), 0, 2'd1, 2'd0, 5'd0, 5'd2);
    // R7 source lane beyond source length
    op("R7", sels(3'b100, 3'b111, 3'b101, 3'b000), 0, 2'd2, 2'd3, 5'd0, 5'd2);
    op("R7", sels(3'b101, 3'b100, 3'b100, 3'b100), 0, 2'd0, 2'd0, 5'd0, 5'd2);
    // R8 reserved code on a live lane
    op("R8", sels(3'b100, 3'b101, 3'b001, 3'b100), 0, 2'd3, 2'd2, 5'd0, 5'd2);
    // R9 odd source, odd destination
    op("R9", sels(3'b100, 3'b101, 3'b110, 3'b111), 0, 2'd3, 2'd3, 5'd3, 5'd2);
    op("R9", sels(3'b100, 3'b101, 3'b110, 3'b111), 0, 2'd3, 2'd3, 5'd2, 5'd31);
    // R11 a full write followed by idle: enables last exactly one cycle
    op("R11", sels(3'b111, 3'b110, 3'b101, 3'b100), 1, 2'd3, 2'd3, 5'd8, 5'd16);
    idle("R11", 3);
    // R2 mixed traffic with varied data and fields
    for (int t = 0; t < 300; t++) begin
      @(negedge clk);
      cur_tag = "R2";
      in_valid = ($urandom_range(0, 3) != 0);
      swz_imm = 12'($urandom);
      is_float = 1'($urandom);
      src_len_m1 = 2'($urandom);
      dst_len_m1 = 2'($urandom);
      src_reg = ($urandom_range(0, 7) == 0) ? 5'($urandom) : {4'($urandom), 1'b0};
      dst_reg = ($urandom_range(0, 7) == 0) ? 5'($urandom) : {4'($urandom), 1'b0};
      src_lo = {$urandom, $urandom};
      src_hi = {$urandom, $urandom};
    end
    idle("R10", 2);
    // R12 reset in the middle of traffic
    op("R12", sels(3'b100, 3'b101, 3'b110, 3'b111), 0, 2'd3, 2'd3, 5'd2, 5'd4);
    rst = 1'b1;
    cur_tag = "R12";
    @(negedge clk);
    rst = 1'b0; in_valid = 1'b0;
    idle("R10", 2);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule